// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a synthesizable single-port synchronous SRAM with a small, parameterised depth. Commands are sampled on a rising clock edge: address, read/write select, byte-lane enables and the load/advance control. The data phase of every operation comes exactly two enabled clock edges after its command, and this holds for writes as well as reads. Because both directions share the same fixed delay, reads and writes can be interleaved on consecutive cycles with no idle slot between them.

Write data is captured in its data phase into a one-entry posted-write register and is retired into the array at the next enabled edge. A read that reaches its data phase while that register still holds a write to the same word returns the posted bytes, merged per lane with the stored word. A load cycle either starts an operation or deselects the device. An advance cycle continues the current burst of four words, in either linear or interleaved order. An active-low clock enable freezes the whole block. The read output has a combinational enable that only forces the data to zero.

Top module: `zbt_sram`

## Requirements
- R1: A read command sampled at an enabled edge delivers its word on `rdData` with `rdValid` high right after the second enabled edge that follows. `rdValid` is low after every other enabled edge and changes only at enabled edges.
- R2: The write data for a command sampled at an enabled edge is taken from `wrData` at the second enabled edge after it. Values on `wrData` at any other edge are not stored.
- R3: Reads and writes may be issued on consecutive enabled edges in any order (W-R, R-W, W-W, R-R). Each one completes with no idle cycle inserted.
- R4: While `clkEnN` is high at an edge, every input is ignored and all state holds, including `rdValid` and the registered read word. Operations continue when the clock enable returns low.
- R5: A load cycle (`advance` low) starts an operation only when `chipEn1N`=0, `chipEn2`=1 and `chipEn3N`=0. With any one of them inactive, the cycle is a deselect: no read is returned and no word is written.
- R6: A deselect does not cancel operations already issued. Their read data still appears, and their write data is still taken and stored.
- R7: `advance`=1 continues the current burst. The operation type comes from the load cycle and `rdWrN` is ignored. The upper address bits stay fixed. With `orderInterleave`=0, the low two bits are (start + n) mod 4 for n = 0..3.
- R8: With `orderInterleave`=1, the low two burst address bits are the start's low two bits XOR n.
- R9: `byteWrEn[i]`=1 writes bits [8i+7:8i] of the addressed word. Lanes with the bit low keep their old contents.
- R10: A read whose data phase falls while a write to the same address is still posted returns that write's enabled lanes merged with the stored word.
- R11: `outEnN`=1 forces `rdData` to zero at once, without a clock. It changes neither `rdValid` nor any stored state.
- R12: After reset, `rdValid` is 0 and `rdData` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| clkEnN | input | 1 | Clock enable, active low; high suspends the block |
| chipEn1N | input | 1 | Chip enable, active low |
| chipEn2 | input | 1 | Chip enable, active high |
| chipEn3N | input | 1 | Chip enable, active low |
| rdWrN | input | 1 | Operation type on a load cycle: 1 read, 0 write |
| advance | input | 1 | 1 continues the burst, 0 loads a new address |
| orderInterleave | input | 1 | Burst order: 0 linear, 1 interleaved |
| byteWrEn | input | LANES | Per-lane write enables, active high |
| addr | input | ADDR_W | Word address |
| wrData | input | LANES*LANE_W | Write data, taken in the data phase |
| outEnN | input | 1 | Asynchronous read output enable, active low |
| rdData | output | LANES*LANE_W | Read data |
| rdValid | output | 1 | High in the data phase of a read |

## Verification
Read results come two enabled edges after the command. The write data for a command is driven on the input during the cycle before its second enabled edge, and a read sees that write from the following edge onward. The bench drives each cycle's inputs shortly after a rising edge and samples the outputs one nanosecond after the next edge. Each row of its vector table therefore carries the write data and the expected read word of the command issued two rows earlier. Suspended edges are not counted, so the suspend test expects the read word only after two more enabled edges. The output-enable check changes `outEnN` between edges and samples again without waiting for a clock.

// File: rtl/zbt_pkg.sv
package zbt_pkg;
  localparam int unsigned BURST_LEN = 4;
  localparam int unsigned CNT_W = $clog2(BURST_LEN);

  // strobes from control to datapath for the op in its data phase
  typedef struct packed {
    logic en;         // this edge is enabled
    logic captureWr;  // write data phase: take wrData
    logic fetchRd;    // read data phase: load output register
  } zbtStrobe_t;
endpackage

// File: rtl/zbt_ctrl.sv
module zbt_ctrl
  import zbt_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned LANES  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEnN,
  input  logic              chipEn1N,
  input  logic              chipEn2,
  input  logic              chipEn3N,
  input  logic              rdWrN,
  input  logic              advance,
  input  logic              orderInterleave,
  input  logic [LANES-1:0]  byteWrEn,
  input  logic [ADDR_W-1:0] addr,
  output zbtStrobe_t        strobe,
  output logic [ADDR_W-1:0] opAddr,
  output logic [LANES-1:0]  opLanes
);
  localparam int unsigned HI_W = ADDR_W - CNT_W;

  logic enable, selected, newLoad, newAdv;
  logic burstOn, burstRead;
  logic [ADDR_W-1:0] burstBase;
  logic [CNT_W-1:0]  burstCnt, nextCnt, advLow;

  logic issueVld, issueRd;
  logic [ADDR_W-1:0] issueAddr;

  logic s1Vld, s1Rd, s2Vld, s2Rd;
  logic [ADDR_W-1:0] s1Addr, s2Addr;
  logic [LANES-1:0]  s1Lanes, s2Lanes;

  assign enable   = !clkEnN;
  assign selected = !chipEn1N && chipEn2 && !chipEn3N;
  assign newLoad  = !advance && selected;
  assign newAdv   = advance && burstOn;
  assign nextCnt  = burstCnt + 1'b1;

  always_comb begin
    if (orderInterleave) advLow = burstBase[CNT_W-1:0] ^ nextCnt;
    else                 advLow = burstBase[CNT_W-1:0] + nextCnt;
  end

  assign issueVld  = newLoad || newAdv;
  assign issueRd   = newLoad ? rdWrN : burstRead;
  assign issueAddr = newLoad ? addr : {burstBase[ADDR_W-1 -: HI_W], advLow};

  // burst tracking
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      burstOn   <= 1'b0;
      burstRead <= 1'b0;
      burstBase <= '0;
      burstCnt  <= '0;
    end else if (enable) begin
      if (!advance) burstOn <= selected;
      if (newLoad) begin
        burstBase <= addr;
        burstCnt  <= '0;
        burstRead <= rdWrN;
      end else if (newAdv) begin
        burstCnt  <= nextCnt;
      end
    end
  end

  // two-stage command pipeline
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Vld <= 1'b0; s1Rd <= 1'b0; s1Addr <= '0; s1Lanes <= '0;
      s2Vld <= 1'b0; s2Rd <= 1'b0; s2Addr <= '0; s2Lanes <= '0;
    end else if (enable) begin
      s1Vld   <= issueVld;
      s1Rd    <= issueRd;
      s1Addr  <= issueAddr;
      s1Lanes <= byteWrEn;
      s2Vld   <= s1Vld;
      s2Rd    <= s1Rd;
      s2Addr  <= s1Addr;
      s2Lanes <= s1Lanes;
    end
  end

  assign strobe.en        = enable;
  assign strobe.captureWr = s2Vld && !s2Rd;
  assign strobe.fetchRd   = s2Vld && s2Rd;
  assign opAddr           = s2Addr;
  assign opLanes          = s2Lanes;
endmodule

// File: rtl/zbt_datapath.sv
module zbt_datapath
  import zbt_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned LANES  = 2,
  parameter int unsigned LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  zbtStrobe_t              strobe,
  input  logic [ADDR_W-1:0]       opAddr,
  input  logic [LANES-1:0]        opLanes,
  input  logic [LANES*LANE_W-1:0] wrData,
  input  logic                    outEnN,
  output logic [LANES*LANE_W-1:0] rdData,
  output logic                    rdValid
);
  localparam int unsigned DEPTH  = 1 << ADDR_W;
  localparam int unsigned DATA_W = LANES * LANE_W;

  logic                postVld;
  logic [ADDR_W-1:0]   postAddr;
  logic [LANES-1:0]    postLanes;
  logic [DATA_W-1:0]   postData;
  logic                fwdHit;
  logic [DATA_W-1:0]   mergedWord;
  logic [DATA_W-1:0]   rdReg;
  logic                vldReg;

  assign fwdHit = postVld && (postAddr == opAddr);

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [LANE_W-1:0] laneMem [DEPTH];

    always_ff @(posedge clk) begin
      if (strobe.en && postVld && postLanes[g])
        laneMem[postAddr] <= postData[g*LANE_W +: LANE_W];
    end

    assign mergedWord[g*LANE_W +: LANE_W] =
      (fwdHit && postLanes[g]) ? postData[g*LANE_W +: LANE_W] : laneMem[opAddr];
  end

  // posted write register, retired at the next enabled edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      postVld   <= 1'b0;
      postAddr  <= '0;
      postLanes <= '0;
      postData  <= '0;
    end else if (strobe.en) begin
      postVld <= strobe.captureWr;
      if (strobe.captureWr) begin
        postAddr  <= opAddr;
        postLanes <= opLanes;
        postData  <= wrData;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdReg  <= '0;
      vldReg <= 1'b0;
    end else if (strobe.en) begin
      vldReg <= strobe.fetchRd;
      if (strobe.fetchRd) rdReg <= mergedWord;
    end
  end

  assign rdData  = outEnN ? '0 : rdReg;
  assign rdValid = vldReg;
endmodule

// File: rtl/zbt_sram.sv
module zbt_sram
  import zbt_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned LANES  = 2,
  parameter int unsigned LANE_W = 8,
  localparam int unsigned DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEnN,
  input  logic              chipEn1N,
  input  logic              chipEn2,
  input  logic              chipEn3N,
  input  logic              rdWrN,
  input  logic              advance,
  input  logic              orderInterleave,
  input  logic [LANES-1:0]  byteWrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              outEnN,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);
  zbtStrobe_t        strobe;
  logic [ADDR_W-1:0] opAddr;
  logic [LANES-1:0]  opLanes;

  zbt_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
    .clk(clk), .rstN(rstN), .clkEnN(clkEnN),
    .chipEn1N(chipEn1N), .chipEn2(chipEn2), .chipEn3N(chipEn3N),
    .rdWrN(rdWrN), .advance(advance), .orderInterleave(orderInterleave),
    .byteWrEn(byteWrEn), .addr(addr),
    .strobe(strobe), .opAddr(opAddr), .opLanes(opLanes)
  );

  zbt_datapath #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .opAddr(opAddr), .opLanes(opLanes), .wrData(wrData),
    .outEnN(outEnN), .rdData(rdData), .rdValid(rdValid)
  );
endmodule

// File: rtl/zbt_sram_chk.sv
module zbt_sram_chk #(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              clkEnN,
  input logic              chipEn1N,
  input logic              chipEn2,
  input logic              chipEn3N,
  input logic              advance,
  input logic              outEnN,
  input logic [DATA_W-1:0] rdData,
  input logic              rdValid
);
  logic deselLoad;
  assign deselLoad = !clkEnN && !advance && !(!chipEn1N && chipEn2 && !chipEn3N);

  // R4
  suspend_valid_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    clkEnN |=> $stable(rdValid));

  // R4
  suspend_data_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clkEnN && !outEnN) |=> (outEnN || $stable(rdData)));

  // R11
  oe_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    outEnN |-> (rdData == '0));

  // R1
  valid_on_enabled_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rdValid) |-> !$past(clkEnN));

  // R5
  deselect_no_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(deselLoad, 2) && !$past(clkEnN) && !clkEnN) |=> !rdValid);
endmodule

bind zbt_sram zbt_sram_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/test_zbt_sram.sv
`timescale 1ns/1ps
module test_zbt_sram;
  localparam int unsigned ADDR_W = 6;
  localparam int unsigned LANES  = 2;
  localparam int unsigned LANE_W = 8;
  localparam int unsigned DATA_W = LANES * LANE_W;

  logic clk = 1'b0;
  logic rstN, clkEnN, chipEn1N, chipEn2, chipEn3N, rdWrN, advance, orderInterleave, outEnN;
  logic [LANES-1:0]  byteWrEn;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] wrData, rdData;
  logic              rdValid;

  int nTests = 0;
  int nFail  = 0;

  always #2 clk = ~clk;

  zbt_sram #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) i_zbt_sram (.*);

  typedef struct packed {
    logic        sel;
    logic        rd;
    logic        adv;
    logic        ilv;
    logic [1:0]  be;
    logic [5:0]  a;
    logic [15:0] wd;   // write data for the command two rows earlier
    logic        ev;   // expected rdValid after this row's edge
    logic [15:0] ed;   // expected rdData when ev
  } vec_t;

  localparam int NVEC = 22;
  localparam vec_t VEC [NVEC] = '{
    '{1'b1,1'b0,1'b0,1'b0,2'd3,6'h05,16'h0000,1'b0,16'h0000}, // 0 W 5
    '{1'b1,1'b0,1'b0,1'b0,2'd3,6'h06,16'h0000,1'b0,16'h0000}, // 1 W 6
    '{1'b1,1'b1,1'b0,1'b0,2'd0,6'h05,16'hA5A5,1'b0,16'h0000}, // 2 R 5
    '{1'b1,1'b1,1'b0,1'b0,2'd0,6'h06,16'h1234,1'b0,16'h0000}, // 3 R 6
    '{1'b1,1'b0,1'b0,1'b0,2'd1,6'h05,16'h0000,1'b1,16'hA5A5}, // 4 W 5 low lane
    '{1'b1,1'b1,1'b0,1'b0,2'd0,6'h05,16'h0000,1'b1,16'h1234}, // 5 R 5
    '{1'b0,1'b0,1'b0,1'b0,2'd0,6'h00,16'hBEEF,1'b0,16'h0000}, // 6 desel
    '{1'b0,1'b0,1'b0,1'b0,2'd0,6'h00,16'h0000,1'b1,16'hA5EF}, // 7 desel, bypass
    '{1'b1,1'b0,1'b0,1'b0,2'd2,6'h06,16'h0000,1'b0,16'h0000}, // 8 W 6 high lane
    '{1'b1,1'b1,1'b0,1'b0,2'd0,6'h06,16'h0000,1'b0,16'h0000}, // 9 R 6
    '{1'b0,1'b0,1'b0,1'b0,2'd0,6'h00,16'h7788,1'b0,16'h0000}, // 10 desel
    '{1'b0,1'b0,1'b0,1'b0,2'd0,6'h00,16'h0000,1'b1,16'h7734}, // 11 desel, bypass
    '{1'b1,1'b0,1'b0,1'b0,2'd3,6'h0E,16'h0000,1'b0,16'h0000}, // 12 W burst 0E
    '{1'b1,1'b0,1'b1,1'b0,2'd3,6'h3F,16'h0000,1'b0,16'h0000}, // 13 adv -> 0F
    '{1'b1,1'b1,1'b1,1'b0,2'd3,6'h3F,16'h1110,1'b0,16'h0000}, // 14 adv -> 0C
    '{1'b1,1'b0,1'b1,1'b0,2'd3,6'h3F,16'h2220,1'b0,16'h0000}, // 15 adv -> 0D
    '{1'b1,1'b1,1'b0,1'b1,2'd0,6'h0D,16'h3330,1'b0,16'h0000}, // 16 R burst 0D ilv
    '{1'b1,1'b0,1'b1,1'b1,2'd0,6'h00,16'h4440,1'b0,16'h0000}, // 17 adv -> 0C
    '{1'b1,1'b0,1'b1,1'b1,2'd0,6'h00,16'h0000,1'b1,16'h4440}, // 18 adv -> 0F
    '{1'b1,1'b0,1'b1,1'b1,2'd0,6'h00,16'h0000,1'b1,16'h3330}, // 19 adv -> 0E
    '{1'b0,1'b0,1'b0,1'b0,2'd0,6'h00,16'h0000,1'b1,16'h2220}, // 20 desel
    '{1'b0,1'b0,1'b0,1'b0,2'd0,6'h00,16'h0000,1'b1,16'h1110}  // 21 desel
  };

  task automatic check(input string what, input logic [15:0] act, input logic [15:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  // one cycle: set inputs, let one rising edge pass, return 1 ns after it
  task automatic cyc(input logic cenN, input logic c1n, input logic c2, input logic c3n,
                     input logic rd, input logic adv, input logic ilv,
                     input logic [1:0] be, input logic [5:0] a, input logic [15:0] wd);
    clkEnN = cenN; chipEn1N = c1n; chipEn2 = c2; chipEn3N = c3n;
    rdWrN = rd; advance = adv; orderInterleave = ilv;
    byteWrEn = be; addr = a; wrData = wd;
    @(posedge clk);
    #1;
  endtask

  task automatic sc(input logic rd, input logic adv, input logic ilv,
                    input logic [1:0] be, input logic [5:0] a, input logic [15:0] wd);
    cyc(1'b0, 1'b0, 1'b1, 1'b0, rd, adv, ilv, be, a, wd);
  endtask

  task automatic desel(input logic [15:0] wd);
    cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 6'h00, wd);
  endtask

  task automatic finish_run;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nTests++;
    nFail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    rstN = 1'b0; outEnN = 1'b0;
    clkEnN = 1'b0; chipEn1N = 1'b1; chipEn2 = 1'b0; chipEn3N = 1'b1;
    rdWrN = 1'b0; advance = 1'b0; orderInterleave = 1'b0;
    byteWrEn = '0; addr = '0; wrData = '0;
    repeat (3) @(posedge clk);
    #1;
    // R12 reset state
    check("R12 rdValid after reset", {15'd0, rdValid}, 16'd0);
    check("R12 rdData after reset", rdData, 16'd0);
    rstN = 1'b1;
    desel(16'h0);

    // vector table: R1 R2 R3 R6 R7 R8 R9 R10
    for (int i = 0; i < NVEC; i++) begin
      cyc(1'b0, !VEC[i].sel, VEC[i].sel, !VEC[i].sel, VEC[i].rd, VEC[i].adv,
          VEC[i].ilv, VEC[i].be, VEC[i].a, VEC[i].wd);
      check($sformatf("R1 R2 R3 vector %0d rdValid", i), {15'd0, rdValid}, {15'd0, VEC[i].ev});
      if (VEC[i].ev)
        check($sformatf("R6 R7 R8 R9 R10 vector %0d rdData", i), rdData, VEC[i].ed);
    end

    // R4: suspend freezes the pipeline and ignores inputs
    sc(1'b0, 1'b0, 1'b0, 2'd3, 6'h14, 16'h0);
    desel(16'h0);
    desel(16'hCAFE);
    sc(1'b1, 1'b0, 1'b0, 2'd0, 6'h14, 16'h0);
    check("R4 before suspend", {15'd0, rdValid}, 16'd0);
    cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 2'd3, 6'h05, 16'hFFFF);
    check("R4 suspended edge 1", {15'd0, rdValid}, 16'd0);
    cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd3, 6'h05, 16'hFFFF);
    check("R4 suspended edge 2", {15'd0, rdValid}, 16'd0);
    desel(16'h0);
    check("R4 first enabled edge", {15'd0, rdValid}, 16'd0);
    desel(16'h0);
    check("R4 data after resume valid", {15'd0, rdValid}, 16'd1);
    check("R4 data after resume", rdData, 16'hCAFE);
    cyc(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 6'h00, 16'h0);
    check("R4 held valid", {15'd0, rdValid}, 16'd1);
    check("R4 held data", rdData, 16'hCAFE);
    desel(16'h0);
    check("R4 suspended cmd ignored a", {15'd0, rdValid}, 16'd0);
    desel(16'h0);
    check("R4 suspended cmd ignored b", {15'd0, rdValid}, 16'd0);

    // R5: each chip enable alone blocks reads and writes
    for (int p = 0; p < 3; p++) begin
      cyc(1'b0, p == 0, p != 1, p == 2, 1'b1, 1'b0, 1'b0, 2'd0, 6'h05, 16'h0);
      desel(16'h0);
      desel(16'h0);
      check($sformatf("R5 pin %0d read blocked", p), {15'd0, rdValid}, 16'd0);
      cyc(1'b0, p == 0, p != 1, p == 2, 1'b0, 1'b0, 1'b0, 2'd3, 6'h05, 16'h0);
      desel(16'h0);
      desel(16'h0000);
      sc(1'b1, 1'b0, 1'b0, 2'd0, 6'h05, 16'h0);
      desel(16'h0);
      desel(16'h0);
      check($sformatf("R5 pin %0d write blocked", p), rdData, 16'hA5EF);
    end

    // R11: output enable masks data only
    sc(1'b1, 1'b0, 1'b0, 2'd0, 6'h06, 16'h0);
    desel(16'h0);
    outEnN = 1'b1;
    desel(16'h0);
    check("R11 valid unmasked", {15'd0, rdValid}, 16'd1);
    check("R11 data masked", rdData, 16'h0000);
    outEnN = 1'b0;
    #1;
    check("R11 data after enable", rdData, 16'h7734);

    // R7: linear read burst wrapping from 0F
    sc(1'b1, 1'b0, 1'b0, 2'd0, 6'h0F, 16'h0);
    sc(1'b0, 1'b1, 1'b0, 2'd0, 6'h00, 16'h0);
    sc(1'b0, 1'b1, 1'b0, 2'd0, 6'h00, 16'h0);
    check("R7 linear beat 0", rdData, 16'h2220);
    sc(1'b0, 1'b1, 1'b0, 2'd0, 6'h00, 16'h0);
    check("R7 linear beat 1", rdData, 16'h3330);
    desel(16'h0);
    check("R7 linear beat 2", rdData, 16'h4440);
    desel(16'h0);
    check("R7 linear beat 3", rdData, 16'h1110);
    check("R7 last beat valid", {15'd0, rdValid}, 16'd1);

    finish_run();
  end
endmodule